// File: doc/BRIEF.md
# Crystal-Selectable CPU and USB Clock Enable Generator

This block runs from a single oscillator clock. It produces two single-cycle clock enables in that domain: one that paces the CPU and one that paces a 6 MHz USB engine. The oscillator is either 24 MHz or 12 MHz. A nonvolatile configuration bit tells the block which one is fitted. The block captures that bit while reset is held and keeps it fixed until the next reset. Because of this, software cannot change the crystal setting at run time.

A small write-only control register holds two run-time bits. The slow bit halves the CPU rate, so the CPU runs at 8 or 4 MHz from a 24 MHz crystal, and at 4 or 2 MHz from a 12 MHz crystal. The clock-out bit sends a registered square-wave copy of the CPU clock to a pin. A new CPU ratio is taken up only when the current CPU period ends, so the CPU never sees a shortened period.

Top module: `cpu_usb_clkgen`

## Requirements
- R1: With the captured crystal bit at 0 (24 MHz), `usb_ce` pulses once every 4 oscillator cycles. With it at 1 (12 MHz), `usb_ce` pulses once every 2 cycles. Both give 6 MHz.
- R2: With the slow bit (bit 2 of `misc_wdata`) at 0, `cpu_ce` pulses once every 3 oscillator cycles, for either crystal. This gives 8 MHz from 24 MHz and 4 MHz from 12 MHz.
- R3: With the slow bit at 1, `cpu_ce` pulses once every 6 oscillator cycles. This gives 4 MHz from 24 MHz and 2 MHz from 12 MHz.
- R4: `opt_xtal12` is sampled only while the internal reset is active. Changing it after reset has been released has no effect on `usb_ce` until the next reset.
- R5: Reset clears the control register. After reset the CPU pulses every 3 cycles and `clk_out` stays low.
- R6: When `misc_wr` is high, the slow bit (bit 2) and the clock-out bit (bit 0) are loaded at the next clock edge. The other bits of `misc_wdata` are ignored. When `misc_wr` is low, both bits hold.
- R7: With the clock-out bit set, `clk_out` is high for 2 of every 3 cycles at ratio 3, and for 3 of every 6 cycles at ratio 6. With the bit clear, `clk_out` is constantly low.
- R8: A change of the slow bit takes effect only at the end of a CPU period. Every interval between consecutive `cpu_ce` pulses is exactly 3 or 6 cycles.
- R9: Asserting `rst_n` immediately forces `cpu_ce`, `usb_ce` and `clk_out` low. Its release passes through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock, 24 or 12 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_xtal12 | input | 1 | Nonvolatile crystal option: 0 = 24 MHz, 1 = 12 MHz |
| misc_wr | input | 1 | Write strobe for the control register |
| misc_wdata | input | 8 | Write data: bit 2 = slow mode, bit 0 = clock output enable |
| cpu_ce | output | 1 | One-cycle CPU clock enable |
| usb_ce | output | 1 | One-cycle 6 MHz USB clock enable |
| clk_out | output | 1 | CPU clock copy for the port pin |

## Verification
Results become due at different times after each kind of stimulus:
- A register write is visible one edge after the strobe.
- A new CPU ratio starts at the next period boundary, which is at most six cycles later.
- `clk_out` follows the divider count with one register of delay.
- Reset release takes two edges through the synchronizer.

The bench therefore waits a settling interval of at least twenty cycles before it measures anything. It then measures intervals between pulses, or counts high cycles over a 12-cycle window (a multiple of both ratios), rather than sampling absolute cycle positions. The ratio-change test records every interval across the switch, and each one must be 3 or 6 cycles.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  typedef struct packed {
    logic slow;
    logic pin_en;
  } misc_t;

  localparam int CPU_IDX = 0;
  localparam int USB_IDX = 1;
  localparam int NUM_DIV = 2;
endpackage

// File: rtl/clkgen_rst_sync.sv
module clkgen_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;
endmodule

// File: rtl/clkgen_cfg.sv
module clkgen_cfg
  import clkgen_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SLOW_BIT = 2,
  parameter int PIN_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opt_i,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              opt_q,
  output misc_t             misc_q
);
  logic  opt_d;
  misc_t misc_d;

  // crystal option: follows the pin only while reset is held
  always_comb begin
    opt_d = rst_n ? opt_q : opt_i;
  end

  always_ff @(posedge clk) begin
    opt_q <= opt_d;
  end

  // run-time control bits
  always_comb begin
    misc_d = misc_q;
    if (wr) begin
      misc_d.slow   = wdata[SLOW_BIT];
      misc_d.pin_en = wdata[PIN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misc_q <= '0;
    end else begin
      misc_q <= misc_d;
    end
  end
endmodule

// File: rtl/clkgen_ce_div.sv
module clkgen_ce_div #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] div_i,
  output logic             ce,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] div_q
);
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] div_d;
  logic             ce_d;
  logic             ce_q;
  logic             wrap;

  // the requested ratio is taken only when a period ends
  always_comb begin
    wrap = (cnt_q == '0);
    ce_d = wrap;
    if (wrap) begin
      cnt_d = div_i - CNT_W'(1);
      div_d = div_i;
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
      div_d = div_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
      ce_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
      ce_q  <= ce_d;
    end
  end

  assign ce = ce_q;
endmodule

// File: rtl/cpu_usb_clkgen.sv
module cpu_usb_clkgen
  import clkgen_pkg::*;
#(
  parameter int CPU_DIV    = 3,
  parameter int USB_DIV_24 = 4,
  parameter int USB_DIV_12 = 2,
  parameter int DATA_W     = 8,
  parameter int SLOW_BIT   = 2,
  parameter int PIN_BIT    = 0
) (
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic              opt_xtal12,
  input  logic              misc_wr,
  input  logic [DATA_W-1:0] misc_wdata,
  output logic              cpu_ce,
  output logic              usb_ce,
  output logic              clk_out
);
  localparam int SLOW_DIV = 2 * CPU_DIV;
  localparam int USB_MAX  = (USB_DIV_24 > USB_DIV_12) ? USB_DIV_24 : USB_DIV_12;
  localparam int MAX_DIV  = (SLOW_DIV > USB_MAX) ? SLOW_DIV : USB_MAX;
  localparam int CNT_W    = $clog2(MAX_DIV + 1);

  logic             rst_sync_n;
  logic             opt_q;
  misc_t            misc_q;
  logic             slow_q;
  logic             pin_en_q;
  logic [CNT_W-1:0] div_sel [NUM_DIV];
  logic [CNT_W-1:0] cnt_vec [NUM_DIV];
  logic [CNT_W-1:0] div_cur [NUM_DIV];
  logic [NUM_DIV-1:0] ce_vec;
  logic             pin_hi;
  logic             pin_d;
  logic             pin_q;

  clkgen_rst_sync i_rst_sync (
    .clk    (osc_clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  clkgen_cfg #(
    .DATA_W   (DATA_W),
    .SLOW_BIT (SLOW_BIT),
    .PIN_BIT  (PIN_BIT)
  ) i_cfg (
    .clk    (osc_clk),
    .rst_n  (rst_sync_n),
    .opt_i  (opt_xtal12),
    .wr     (misc_wr),
    .wdata  (misc_wdata),
    .opt_q  (opt_q),
    .misc_q (misc_q)
  );

  assign slow_q   = misc_q.slow;
  assign pin_en_q = misc_q.pin_en;

  // ratio selection: CPU follows slow mode, USB follows the crystal
  always_comb begin
    div_sel[CPU_IDX] = slow_q ? CNT_W'(SLOW_DIV) : CNT_W'(CPU_DIV);
    div_sel[USB_IDX] = opt_q ? CNT_W'(USB_DIV_12) : CNT_W'(USB_DIV_24);
  end

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    clkgen_ce_div #(
      .CNT_W (CNT_W)
    ) i_div (
      .clk   (osc_clk),
      .rst_n (rst_sync_n),
      .div_i (div_sel[g]),
      .ce    (ce_vec[g]),
      .cnt_q (cnt_vec[g]),
      .div_q (div_cur[g])
    );
  end

  // pin waveform: high in the upper half of the running CPU count
  always_comb begin
    pin_hi = (cnt_vec[CPU_IDX] >= (div_cur[CPU_IDX] >> 1));
    pin_d  = pin_en_q & pin_hi;
  end

  always_ff @(posedge osc_clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pin_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
    end
  end

  assign cpu_ce  = ce_vec[CPU_IDX];
  assign usb_ce  = ce_vec[USB_IDX];
  assign clk_out = pin_q;
endmodule

// File: rtl/clkgen_chk.sv
module clkgen_chk #(
  parameter int CPU_DIV    = 3,
  parameter int USB_DIV_24 = 4,
  parameter int USB_DIV_12 = 2,
  parameter int DATA_W     = 8,
  parameter int SLOW_BIT   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              opt_q,
  input logic              slow_q,
  input logic              pin_en_q,
  input logic              wr,
  input logic [DATA_W-1:0] wdata,
  input logic              cpu_ce,
  input logic              usb_ce,
  input logic              clk_out
);
  logic [7:0] cpu_gap;
  logic [7:0] usb_gap;
  logic       cpu_seen;
  logic       usb_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_gap  <= 8'd0;
      usb_gap  <= 8'd0;
      cpu_seen <= 1'b0;
      usb_seen <= 1'b0;
    end else begin
      cpu_gap  <= cpu_ce ? 8'd1 : ((cpu_gap == 8'hFF) ? cpu_gap : cpu_gap + 8'd1);
      usb_gap  <= usb_ce ? 8'd1 : ((usb_gap == 8'hFF) ? usb_gap : usb_gap + 8'd1);
      cpu_seen <= cpu_seen | cpu_ce;
      usb_seen <= usb_seen | usb_ce;
    end
  end

  // R1
  usb_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_ce && usb_seen) |-> (usb_gap == 8'(opt_q ? USB_DIV_12 : USB_DIV_24)));

  // R8
  cpu_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce && cpu_seen) |-> (cpu_gap == 8'(CPU_DIV) || cpu_gap == 8'(2 * CPU_DIV)));

  // R4
  opt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(opt_q));

  // R6
  slow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (slow_q == $past(wdata[SLOW_BIT])));

  // R6
  slow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(slow_q));

  // R7
  pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out |-> $past(pin_en_q));
endmodule

bind cpu_usb_clkgen clkgen_chk #(
  .CPU_DIV    (CPU_DIV),
  .USB_DIV_24 (USB_DIV_24),
  .USB_DIV_12 (USB_DIV_12),
  .DATA_W     (DATA_W),
  .SLOW_BIT   (SLOW_BIT)
) i_chk (
  .clk      (osc_clk),
  .rst_n    (rst_sync_n),
  .opt_q    (opt_q),
  .slow_q   (slow_q),
  .pin_en_q (pin_en_q),
  .wr       (misc_wr),
  .wdata    (misc_wdata),
  .cpu_ce   (cpu_ce),
  .usb_ce   (usb_ce),
  .clk_out  (clk_out)
);

// File: tb/test_cpu_usb_clkgen.sv
module test_cpu_usb_clkgen;
  logic       osc_clk;
  logic       rst_n;
  logic       opt_xtal12;
  logic       misc_wr;
  logic [7:0] misc_wdata;
  logic       cpu_ce;
  logic       usb_ce;
  logic       clk_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  cpu_usb_clkgen i_cpu_usb_clkgen (
    .osc_clk    (osc_clk),
    .rst_n      (rst_n),
    .opt_xtal12 (opt_xtal12),
    .misc_wr    (misc_wr),
    .misc_wdata (misc_wdata),
    .cpu_ce     (cpu_ce),
    .usb_ce     (usb_ce),
    .clk_out    (clk_out)
  );

  initial osc_clk = 1'b0;
  always #2 osc_clk = ~osc_clk;

  // fields: crystal, slow, pin enable, cpu interval, usb interval, pin highs in 12 cycles
  localparam logic [14:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 4'd3, 4'd4, 4'd0},
    {1'b0, 1'b0, 1'b1, 4'd3, 4'd4, 4'd8},
    {1'b0, 1'b1, 1'b0, 4'd6, 4'd4, 4'd0},
    {1'b0, 1'b1, 1'b1, 4'd6, 4'd4, 4'd6},
    {1'b1, 1'b0, 1'b0, 4'd3, 4'd2, 4'd0},
    {1'b1, 1'b0, 1'b1, 4'd3, 4'd2, 4'd8},
    {1'b1, 1'b1, 1'b0, 4'd6, 4'd2, 4'd0},
    {1'b1, 1'b1, 1'b1, 4'd6, 4'd2, 4'd6}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge osc_clk);
  endtask

  task automatic do_reset(input logic opt);
    @(negedge osc_clk);
    rst_n      = 1'b0;
    opt_xtal12 = opt;
    misc_wr    = 1'b0;
    misc_wdata = 8'h00;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(20);
  endtask

  task automatic reg_write(input logic [7:0] d);
    @(negedge osc_clk);
    misc_wr    = 1'b1;
    misc_wdata = d;
    @(negedge osc_clk);
    misc_wr    = 1'b0;
    misc_wdata = 8'h00;
    wait_cyc(20);
  endtask

  task automatic cpu_gap(output int n);
    while (!cpu_ce) @(negedge osc_clk);
    n = 0;
    do begin
      @(negedge osc_clk);
      n++;
    end while (!cpu_ce);
  endtask

  task automatic usb_gap(output int n);
    while (!usb_ce) @(negedge osc_clk);
    n = 0;
    do begin
      @(negedge osc_clk);
      n++;
    end while (!usb_ce);
  endtask

  task automatic pin_highs(output int n);
    n = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge osc_clk);
      if (clk_out) n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge osc_clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int g;
    int p;
    rst_n      = 1'b0;
    opt_xtal12 = 1'b0;
    misc_wr    = 1'b0;
    misc_wdata = 8'h00;
    wait_cyc(3);
    // R9: outputs held low while reset is active
    chk("R9 cpu_ce in reset", int'(cpu_ce), 0);
    chk("R9 usb_ce in reset", int'(usb_ce), 0);
    chk("R9 clk_out in reset", int'(clk_out), 0);

    // table walk: R1 R2 R3 R7
    for (int v = 0; v < 8; v++) begin
      do_reset(VEC[v][14]);
      reg_write({5'b0, VEC[v][13], 1'b0, VEC[v][12]});
      cpu_gap(g);
      chk(VEC[v][13] ? "R3 cpu interval" : "R2 cpu interval", g, int'(VEC[v][11:8]));
      usb_gap(g);
      chk("R1 usb interval", g, int'(VEC[v][7:4]));
      pin_highs(p);
      chk("R7 pin high count", p, int'(VEC[v][3:0]));
    end

    // R5: reset clears slow and pin bits
    reg_write(8'h05);
    do_reset(1'b0);
    cpu_gap(g);
    chk("R5 cpu interval after reset", g, 3);
    pin_highs(p);
    chk("R5 pin low after reset", p, 0);

    // R4: option input changes after release are ignored
    opt_xtal12 = 1'b1;
    wait_cyc(10);
    usb_gap(g);
    chk("R4 usb interval keeps 24 MHz", g, 4);
    do_reset(1'b1);
    opt_xtal12 = 1'b0;
    wait_cyc(10);
    usb_gap(g);
    chk("R4 usb interval keeps 12 MHz", g, 2);

    // R6: other bits of the write are ignored
    reg_write(8'hFA);
    cpu_gap(g);
    chk("R6 ignored bits cpu interval", g, 3);
    pin_highs(p);
    chk("R6 ignored bits pin", p, 0);
    // R6: held when no strobe
    reg_write(8'h05);
    @(negedge osc_clk);
    misc_wdata = 8'h00;
    wait_cyc(20);
    cpu_gap(g);
    chk("R6 hold slow without strobe", g, 6);
    pin_highs(p);
    chk("R6 hold pin without strobe", p, 6);

    // R8: switch ratio while running; every interval is 3 or 6
    reg_write(8'h00);
    cpu_gap(g);
    @(negedge osc_clk);
    misc_wr    = 1'b1;
    misc_wdata = 8'h04;
    @(negedge osc_clk);
    misc_wr    = 1'b0;
    misc_wdata = 8'h00;
    for (int k = 0; k < 5; k++) begin
      cpu_gap(g);
      chk("R8 interval is 3 or 6", int'(g == 3 || g == 6), 1);
    end
    chk("R8 final interval slow", g, 6);
    @(negedge osc_clk);
    misc_wr    = 1'b1;
    misc_wdata = 8'h00;
    @(negedge osc_clk);
    misc_wr    = 1'b0;
    for (int k = 0; k < 5; k++) begin
      cpu_gap(g);
      chk("R8 interval is 3 or 6", int'(g == 3 || g == 6), 1);
    end
    chk("R8 final interval fast", g, 3);

    // R9: asynchronous assertion mid-run with the pin enabled
    reg_write(8'h01);
    while (!clk_out) @(negedge osc_clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R9 async clk_out", int'(clk_out), 0);
    chk("R9 async cpu_ce", int'(cpu_ce), 0);
    chk("R9 async usb_ce", int'(usb_ce), 0);
    wait_cyc(2);
    rst_n = 1'b1;
    @(negedge osc_clk);
    chk("R9 sync release first edge", int'(cpu_ce | usb_ce), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule